// File: doc/BRIEF.md
# Transmit Packet Formatter with Timestamp Insertion

The block takes one outbound packet at a time from a processor. It holds the packet in a staging buffer that fits a single packet, then sends it to an Ethernet transmit port one byte per clock. The processor writes a sequence of 32-bit words. The first word is a control word. The remaining words are the stored packet: two zero fill bytes, then the frame from the destination address to the last payload byte, with no FCS. The block drops the control word and the fill bytes and sends only the frame.

A packet starts only while the port reports that it is free of higher-priority traffic. Once a packet has started, it runs to its last byte. The block can replace four frame bytes with a 32-bit timestamp, sent most significant byte first. The timestamp comes from a free-running counter and is latched on the clock edge that starts the packet. The control word also carries the IP header offset and the checksum request flags. The block passes these on as sideband outputs beside the byte stream, and a later stage computes the checksums.

Top module: `tx_pkt_formatter`

## Requirements
- R1: While reset is high and after it is released, `buf_full`, `tx_valid`, `tx_first`, `tx_last`, `ts_err`, `tx_data` and all sideband outputs are low.
- R2: When `buf_full` is low, the first accepted word is the control word. Its fields are: byte length in bits [31:21], timestamp word offset in bits [20:12], timestamp enable in bit [11], IP header word offset in bits [10:6], UDP checksum flag in bit [5], IPv6 flag in bit [4], IPv4 flag in bit [3], and bits [2:0] unused. The block then accepts ceil((length+2)/4) data words. `buf_full` is high from the cycle after the edge that accepts the last of these words.
- R3: A packet starts on the first rising edge at which `buf_full` is high and `port_busy` is low. `tx_valid` is high from the following cycle. No packet starts on an edge at which `port_busy` is high.
- R4: Stored bytes are big-endian: bits [31:24] of a word come first. Bits [31:16] of the first data word are fill and are never sent. Frame byte i is sent in the i-th cycle of the packet. `tx_first` is high on byte 0 and `tx_last` is high on byte length−1. `port_busy` has no effect once a packet has started.
- R5: `buf_full` goes low after the edge that consumes the last byte. The next control word is accepted from the following cycle onward.
- R6: Words presented while `buf_full` is high are ignored and do not change the packet that is sent.
- R7: Timestamp insertion needs two conditions: the enable bit is 1, and 4·offset+6 ≤ length. When both hold, frame bytes 4·offset+2 through 4·offset+5 are replaced by the counter value, most significant byte first. The counter reads 0 on the first edge after reset and advances by one per clock. The value used is the one the counter held just before the starting edge.
- R8: If the enable bit is 1 but 4·offset+6 > length, the frame is sent unmodified and `ts_err` is high on every byte of that packet.
- R9: While `tx_valid` is high, `has_ipv4`, `has_ipv6` and `ip_hdr_off` follow the control word. `udp_csum_req` equals the UDP flag ANDed with (IPv4 OR IPv6). All four outputs are zero while idle.
- R10: A packet of length 0 sends no bytes. `buf_full` goes low at the edge where that packet would have started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Processor word strobe |
| wr_data | input | 32 | Processor word (control word, then stored packet) |
| buf_full | output | 1 | Staging buffer holds a complete packet |
| port_busy | input | 1 | Port is busy with higher-priority traffic |
| tx_valid | output | 1 | A frame byte is on `tx_data` |
| tx_data | output | 8 | Frame byte |
| tx_first | output | 1 | First byte of the frame |
| tx_last | output | 1 | Last byte of the frame |
| ts_err | output | 1 | Timestamp requested but does not fit |
| has_ipv4 | output | 1 | Frame carries an IPv4 header |
| has_ipv6 | output | 1 | Frame carries an IPv6 header |
| udp_csum_req | output | 1 | UDP checksum requested (qualified by the IP flags) |
| ip_hdr_off | output | 5 | IP header word offset |

## Verification
The timing contract is as follows. `buf_full` is due one cycle after the last data word is sampled. The first byte is due one cycle after the first edge that sees the buffer full and the port free. Each further byte follows one cycle after the previous one. `buf_full` falls one cycle after the last byte. The bench mirrors this with a behavioural model that is advanced on each rising edge from the sampled inputs alone. The model keeps the received words in a queue and the counter as an integer, and it predicts every output for the coming cycle. Every output is compared with the prediction at the falling edge, half a period after the edge that produced it. The timestamp bytes are expected from the model's own count of edges since reset.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int LEN_W  = 11;          // byte length field width
    localparam int OFF_W  = 9;           // timestamp word offset width
    localparam int IPO_W  = 5;           // IP header word offset width
    localparam int POS_W  = LEN_W + 1;   // byte position arithmetic width
    localparam int ADDR_W = POS_W - 2;   // word address derived from a byte position
    localparam int TS_W   = 32;          // timestamp width

    // Field order mirrors the control word bit layout, MSB first.
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [OFF_W-1:0] ts_off;
        logic             ts_en;
        logic [IPO_W-1:0] ip_off;
        logic             udp;
        logic             ipv6;
        logic             ipv4;
        logic [2:0]       rsvd;
    } txf_ctrl_t;

    typedef enum logic {ST_IDLE, ST_SEND} txf_state_e;

    // Data words after the control word: fill (2 bytes) plus frame, rounded up.
    function automatic logic [POS_W-1:0] words_needed(input logic [LEN_W-1:0] len);
        return ({1'b0, len} + POS_W'(5)) >> 2;
    endfunction

    // First frame byte covered by the timestamp.
    function automatic logic [POS_W-1:0] ts_first_byte(input txf_ctrl_t c);
        return {1'b0, c.ts_off, 2'b00} + POS_W'(2);
    endfunction

    // All four timestamp bytes lie inside the frame.
    function automatic logic ts_fits(input txf_ctrl_t c);
        return (ts_first_byte(c) + POS_W'(4)) <= {1'b0, c.len};
    endfunction

endpackage

// File: rtl/txf_stamp_ctr.sv
module txf_stamp_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

endmodule

// File: rtl/txf_wr_buf.sv
module txf_wr_buf
    import txf_pkg::*;
#(
    parameter int DEPTH = 513,
    parameter int AW    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [31:0]       wr_data,
    input  logic              release_i,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_word,
    output txf_ctrl_t         ctrl_o,
    output logic              full_o
);

    localparam logic [POS_W-1:0] DEPTH_C = POS_W'(DEPTH);

    logic [31:0]      mem [DEPTH];
    logic             have_ctrl;
    logic [POS_W-1:0] wcnt;
    logic             take_hdr;
    logic             take_body;
    logic [POS_W-1:0] need;

    assign take_hdr  = wr_valid && !full_o && !have_ctrl;
    assign take_body = wr_valid && !full_o && have_ctrl;
    assign need      = words_needed(ctrl_o.len);

    always_ff @(posedge clk) begin
        if (rst) begin
            full_o    <= 1'b0;
            have_ctrl <= 1'b0;
            wcnt      <= '0;
            ctrl_o    <= '0;
        end else if (release_i) begin
            full_o    <= 1'b0;
            have_ctrl <= 1'b0;
            wcnt      <= '0;
        end else if (take_hdr) begin
            ctrl_o    <= txf_ctrl_t'(wr_data);
            have_ctrl <= 1'b1;
        end else if (take_body) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt + 1'b1 == need) full_o <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take_body && wcnt < DEPTH_C) mem[wcnt[AW-1:0]] <= wr_data;
    end

    assign rd_word = ({2'b00, rd_addr} < DEPTH_C) ? mem[rd_addr[AW-1:0]] : '0;

    // R6: a full buffer takes no further words until it is released
    a_r6_hold_when_full: assert property (@(posedge clk) disable iff (rst)
        full_o && !release_i |=> full_o && $stable(wcnt) && $stable(ctrl_o));

    // R2: the buffer reports full only once the whole stored packet is in
    a_r2_full_at_count: assert property (@(posedge clk) disable iff (rst)
        $rose(full_o) |-> wcnt == need);

endmodule

// File: rtl/txf_tx_seq.sv
module txf_tx_seq
    import txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              full_i,
    input  logic              port_busy,
    input  txf_ctrl_t         ctrl_i,
    input  logic [TS_W-1:0]   cnt_i,
    input  logic [31:0]       rd_word_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              release_o,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              tx_last,
    output logic              ts_err,
    output logic              has_ipv4,
    output logic              has_ipv6,
    output logic              udp_csum_req,
    output logic [IPO_W-1:0]  ip_hdr_off
);

    txf_state_e       state;
    logic [LEN_W-1:0] idx;
    logic [TS_W-1:0]  ts_q;
    logic             sending;
    logic             start;
    logic             last;
    logic             fits;
    logic             in_ts;
    logic [POS_W-1:0] ipos;
    logic [POS_W-1:0] spos;
    logic [POS_W-1:0] tpos;
    logic [1:0]       lane;
    logic [1:0]       k;
    logic [7:0]       raw_b;
    logic [7:0]       ts_b;
    logic             unused_rsvd;

    assign unused_rsvd = ^ctrl_i.rsvd;

    assign sending = (state == ST_SEND);
    assign start   = !sending && full_i && !port_busy;
    assign last    = sending && (idx == ctrl_i.len - 1'b1);

    // Frame byte i sits at stored byte i+2 (after the fill).
    assign ipos      = {1'b0, idx};
    assign spos      = ipos + POS_W'(2);
    assign rd_addr_o = spos[POS_W-1:2];
    assign lane      = spos[1:0];

    assign fits  = ts_fits(ctrl_i);
    assign tpos  = ts_first_byte(ctrl_i);
    assign in_ts = ctrl_i.ts_en && fits && (ipos >= tpos) && (ipos < tpos + POS_W'(4));
    assign k     = ipos[1:0] - tpos[1:0];

    always_comb begin
        unique case (lane)
            2'd0: raw_b = rd_word_i[31:24];
            2'd1: raw_b = rd_word_i[23:16];
            2'd2: raw_b = rd_word_i[15:8];
            default: raw_b = rd_word_i[7:0];
        endcase
        unique case (k)
            2'd0: ts_b = ts_q[31:24];
            2'd1: ts_b = ts_q[23:16];
            2'd2: ts_b = ts_q[15:8];
            default: ts_b = ts_q[7:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            ts_q  <= '0;
        end else if (start) begin
            if (ctrl_i.len != '0) begin
                state <= ST_SEND;
                idx   <= '0;
                ts_q  <= cnt_i;
            end
        end else if (sending) begin
            if (last) begin
                state <= ST_IDLE;
                idx   <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign release_o    = (start && ctrl_i.len == '0) || last;
    assign tx_valid     = sending;
    assign tx_data      = sending ? (in_ts ? ts_b : raw_b) : 8'h00;
    assign tx_first     = sending && (idx == '0);
    assign tx_last      = last;
    assign ts_err       = sending && ctrl_i.ts_en && !fits;
    assign has_ipv4     = sending && ctrl_i.ipv4;
    assign has_ipv6     = sending && ctrl_i.ipv6;
    assign udp_csum_req = sending && ctrl_i.udp && (ctrl_i.ipv4 || ctrl_i.ipv6);
    assign ip_hdr_off   = sending ? ctrl_i.ip_off : '0;

    // R3: a packet never begins on an edge where the port was busy
    a_r3_start_when_free: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> !$past(port_busy));

    // R4: once started, bytes flow every cycle until the last one
    a_r4_no_gap: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_last |=> tx_valid && !tx_first);

    // R5: the cycle after the last byte carries no byte
    a_r5_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        tx_last |=> !tx_valid);

    // R9: a UDP checksum request always comes with an IP flag
    a_r9_udp_qualified: assert property (@(posedge clk) disable iff (rst)
        udp_csum_req |-> (has_ipv4 || has_ipv6));

endmodule

// File: rtl/tx_pkt_formatter.sv
module tx_pkt_formatter
    import txf_pkg::*;
#(
    parameter int MAX_LEN = 2047
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    output logic             buf_full,
    input  logic             port_busy,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_first,
    output logic             tx_last,
    output logic             ts_err,
    output logic             has_ipv4,
    output logic             has_ipv6,
    output logic             udp_csum_req,
    output logic [IPO_W-1:0] ip_hdr_off
);

    localparam int DEPTH = (MAX_LEN + 5) / 4;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    txf_ctrl_t         ctrl;
    logic [TS_W-1:0]   stamp;
    logic [31:0]       rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic              release_b;

    txf_stamp_ctr #(.W(TS_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .count (stamp)
    );

    txf_wr_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .release_i (release_b),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word),
        .ctrl_o    (ctrl),
        .full_o    (buf_full)
    );

    txf_tx_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .full_i       (buf_full),
        .port_busy    (port_busy),
        .ctrl_i       (ctrl),
        .cnt_i        (stamp),
        .rd_word_i    (rd_word),
        .rd_addr_o    (rd_addr),
        .release_o    (release_b),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_first     (tx_first),
        .tx_last      (tx_last),
        .ts_err       (ts_err),
        .has_ipv4     (has_ipv4),
        .has_ipv6     (has_ipv6),
        .udp_csum_req (udp_csum_req),
        .ip_hdr_off   (ip_hdr_off)
    );

    // R5: the buffer stays full for as long as its packet is on the wire
    a_r5_full_while_sending: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> buf_full);

    // R4: frame delimiters only appear on valid bytes
    a_r4_marks_valid: assert property (@(posedge clk) disable iff (rst)
        (tx_first || tx_last) |-> tx_valid);

endmodule

// File: tb/tx_pkt_formatter_tb.sv
`timescale 1ns/1ps
module tx_pkt_formatter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        port_busy = 1'b0;
    logic        buf_full, tx_valid, tx_first, tx_last, ts_err;
    logic        has_ipv4, has_ipv6, udp_csum_req;
    logic [7:0]  tx_data;
    logic [4:0]  ip_hdr_off;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int busy_mode = 0;   // 0 free, 1 busy, 2 random
    int junk_count = 0;
    bit armed = 0;

    // reference model state
    bit          m_full, m_send, m_hc;
    int          m_idx;
    logic [31:0] m_ctrl;
    logic [31:0] m_cnt, m_ts;
    logic [31:0] dq[$];

    always #2 clk = ~clk;

    tx_pkt_formatter u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .buf_full(buf_full), .port_busy(port_busy), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
        .ts_err(ts_err), .has_ipv4(has_ipv4), .has_ipv6(has_ipv6),
        .udp_csum_req(udp_csum_req), .ip_hdr_off(ip_hdr_off)
    );

    function automatic int f_len(logic [31:0] c); return int'(c[31:21]); endfunction
    function automatic int f_need(int len); return (len + 5) / 4; endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // behavioural model, advanced from sampled inputs on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_full = 0; m_send = 0; m_hc = 0; m_idx = 0;
            m_cnt = 0; m_ts = 0; m_ctrl = 0; dq.delete();
        end else begin
            bit st, fin;
            st  = !m_send && m_full && !port_busy;
            fin = m_send && (m_idx == f_len(m_ctrl) - 1);
            if (wr_valid && !m_full) begin
                if (!m_hc) begin m_ctrl = wr_data; m_hc = 1; end
                else begin
                    dq.push_back(wr_data);
                    if (dq.size() == f_need(f_len(m_ctrl))) m_full = 1;
                end
            end
            if (st) begin
                if (f_len(m_ctrl) == 0) begin m_full = 0; m_hc = 0; dq.delete(); end
                else begin m_send = 1; m_idx = 0; m_ts = m_cnt; end
            end else if (m_send) begin
                if (fin) begin m_send = 0; m_full = 0; m_hc = 0; dq.delete(); end
                else m_idx++;
            end
            m_cnt = m_cnt + 1;
        end
    end

    // compare every output each cycle, half a period after the edge
    always @(negedge clk) begin
        if (armed && !rst) begin
            int len, off, tp, sb;
            bit en, fits, in_ts;
            logic [7:0] eb;
            len  = f_len(m_ctrl);
            off  = int'(m_ctrl[20:12]);
            en   = m_ctrl[11];
            tp   = 4 * off + 2;
            fits = (tp + 4) <= len;
            in_ts = 0;
            eb = 8'h00;
            if (m_send) begin
                sb = m_idx + 2;
                eb = dq[sb / 4][8*(3 - sb % 4) +: 8];
                if (en && fits && m_idx >= tp && m_idx < tp + 4) begin
                    in_ts = 1;
                    eb = m_ts[8*(3 - (m_idx - tp)) +: 8];
                end
            end
            chk(buf_full === m_full, "R2 R5", "buf_full", buf_full, m_full);
            chk(tx_valid === m_send, "R3", "tx_valid", tx_valid, m_send);
            chk(tx_data === eb, in_ts ? "R7" : "R4", "tx_data", tx_data, eb);
            chk(tx_first === (m_send && m_idx == 0), "R4", "tx_first", tx_first, m_send && m_idx == 0);
            chk(tx_last === (m_send && m_idx == len - 1), "R4", "tx_last", tx_last, m_send && m_idx == len - 1);
            chk(ts_err === (m_send && en && !fits), "R8", "ts_err", ts_err, m_send && en && !fits);
            chk(has_ipv4 === (m_send && m_ctrl[3]), "R9", "has_ipv4", has_ipv4, m_send && m_ctrl[3]);
            chk(has_ipv6 === (m_send && m_ctrl[4]), "R9", "has_ipv6", has_ipv6, m_send && m_ctrl[4]);
            chk(udp_csum_req === (m_send && m_ctrl[5] && (m_ctrl[3] || m_ctrl[4])), "R9",
                "udp_csum_req", udp_csum_req, m_send && m_ctrl[5] && (m_ctrl[3] || m_ctrl[4]));
            chk(ip_hdr_off === (m_send ? m_ctrl[10:6] : 5'd0), "R9", "ip_hdr_off",
                ip_hdr_off, m_send ? m_ctrl[10:6] : 5'd0);
        end
    end

    // port busy pattern
    always @(negedge clk) begin
        case (busy_mode)
            0: port_busy <= 1'b0;
            1: port_busy <= 1'b1;
            default: port_busy <= 1'($urandom_range(0, 1));
        endcase
    end

    function automatic logic [31:0] mk_ctrl(int len, int toff, bit ten, int ipo,
                                            bit udp, bit v6, bit v4);
        return {11'(len), 9'(toff), ten, 5'(ipo), udp, v6, v4, 3'b101};
    endfunction

    task automatic run_pkt(input logic [31:0] ctrl, input int seed,
                           input int hold, input int bmode);
        int len, nw;
        logic [7:0] fr[$];
        len = f_len(ctrl);
        nw  = f_need(len);
        for (int i = 0; i < len; i++) fr.push_back(8'(seed + i * 7));
        while (m_full || m_hc) @(negedge clk);
        busy_mode = (hold > 0) ? 1 : bmode;
        for (int w = 0; w <= nw; w++) begin
            logic [31:0] word;
            word = ctrl;
            if (w > 0) begin
                for (int b = 0; b < 4; b++) begin
                    int s;
                    s = 4 * (w - 1) + b;
                    word[8*(3-b) +: 8] = (s < 2 || s - 2 >= len) ? 8'h00 : fr[s - 2];
                end
            end
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = word;
        end
        @(negedge clk);
        wr_valid = 1'b0;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            busy_mode = bmode;
        end
        // R6: junk words offered while the buffer is full must be ignored
        forever begin
            @(negedge clk);
            if (!m_full && !m_hc) break;
            if (m_send && m_idx + 2 <= f_len(m_ctrl)) begin
                wr_valid = 1'b1;
                wr_data  = 32'hA5C3_0F00 ^ 32'(m_idx);
                junk_count++;
            end else begin
                wr_valid = 1'b0;
            end
        end
        wr_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!buf_full && !tx_valid && !tx_first && !tx_last && !ts_err, "R1", "flags", 
            {buf_full, tx_valid, tx_first, tx_last, ts_err}, 0);
        chk(tx_data == 0 && !has_ipv4 && !has_ipv6 && !udp_csum_req && ip_hdr_off == 0,
            "R1", "sideband", {tx_data, has_ipv4, has_ipv6, udp_csum_req, ip_hdr_off}, 0);
        rst = 1'b0;
        @(negedge clk);
        armed = 1;
        chk(!buf_full && !tx_valid, "R1", "after release", {buf_full, tx_valid}, 0);

        run_pkt(mk_ctrl(64, 0, 0, 3, 1, 0, 1), 11, 0, 0);     // R4 R9 plain frame
        run_pkt(mk_ctrl(60, 5, 1, 4, 0, 1, 0), 40, 20, 2);    // R3 hold off, R7 stamp
        run_pkt(mk_ctrl(30, 6, 1, 2, 1, 1, 1), 90, 0, 2);     // R7 exact fit
        run_pkt(mk_ctrl(30, 7, 1, 2, 0, 0, 1), 13, 0, 2);     // R8 one word too far
        run_pkt(mk_ctrl(48, 0, 0, 9, 1, 0, 0), 77, 0, 0);     // R9 udp without IP
        run_pkt(mk_ctrl(1, 0, 1, 0, 0, 0, 0), 5, 0, 2);       // R8 single byte
        run_pkt(mk_ctrl(0, 0, 0, 0, 0, 0, 0), 0, 3, 0);       // R10 empty packet
        // R10: empty packet released without any byte
        chk(!buf_full && !tx_valid, "R10", "empty packet drained", {buf_full, tx_valid}, 0);
        run_pkt(mk_ctrl(61, 0, 1, 5, 1, 1, 0), 200, 0, 2);    // R7 stamp at byte 2
        run_pkt(mk_ctrl(2047, 510, 1, 31, 1, 0, 1), 3, 0, 2); // R7 largest fitting
        run_pkt(mk_ctrl(2047, 511, 1, 1, 0, 1, 0), 8, 0, 0);  // R8 largest offset
        // R6: junk was presented during full periods
        chk(junk_count > 0, "R6", "junk words offered", junk_count, 1);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule